// File: doc/BRIEF.md
# Dual-Rank Serial-to-Parallel Output Register

This block turns a serial bit stream into a parallel word through two register ranks. A shift rank of eight stages takes one bit from the serial input on every rising edge of its shift clock. A separate storage rank copies all eight stages at once on the rising edge of its own storage clock. The storage rank drives eight parallel pins. These pins float when the active-low output enable is high.

The last shift stage also leaves the block on a cascade output. That output always drives, whatever the output enable does, so several instances can be chained into one longer shift path. An asynchronous active-low clear empties the shift rank only. The storage rank keeps its word until the next storage edge. The two clocks may be tied together. In that case the storage rank always shows the shift state from one edge earlier.

Top module: `srpo_dual_rank`

## Requirements
- R1: On each rising shift-clock edge with clear high, stage 0 takes the serial input and stage i takes the old value of stage i-1, for i from 1 to 7.
- R2: A low clear sets all shift stages to 0 at once, without a clock edge. While clear stays low, shift-clock edges do not move the chain.
- R3: Clear has no effect on the storage rank. The parallel pins keep their word until a later storage edge loads the zeros.
- R4: A rising storage-clock edge copies shift stage i to parallel bit i in one step, so bit 0 (pin A) is stage 0 and bit 7 (pin H) is stage 7. Shift edges alone leave the parallel pins unchanged.
- R5: With the output enable high, all eight parallel pins are high impedance. With it low, they drive the storage rank.
- R6: The cascade output always equals shift stage 7, including while the output enable is high.
- R7: With the two clocks tied, after each common edge the parallel word equals the shift state from before that edge.
- R8: A storage edge captures the chain whatever the levels of the serial input and the output enable. A word captured while the pins float appears when the enable goes low.
- R9: In two instances chained through the cascade output, 16 shifts followed by one storage edge show the first 8 bits shifted on the second instance and the last 8 on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk_i | input | 1 | Shift clock, rising edge active |
| st_clk_i | input | 1 | Storage clock, rising edge active |
| clr_ni | input | 1 | Asynchronous clear of the shift rank, active low |
| ser_i | input | 1 | Serial data into stage 0 |
| oe_ni | input | 1 | Parallel output enable, active low |
| par_o | output | 8 | Three-state parallel outputs, bit 0 is pin A |
| casc_o | output | 1 | Cascade output, carries stage 7 |

## Verification
The assertions assume that the clocks are free of glitches. They also assume that the clear and the serial input never change in the same instant as a shift-clock edge. The shift checks start only on the second edge after a clear, so no check spans a clear. The bench makes each clock by gating a free-running base clock with an enable that it changes only on the falling edge of the base clock. It changes the serial input, the clear and the output enable on that falling edge as well. The parallel pins are read through pull-ups, so a floating bus reads as all ones. For the same reason, the enable checks load words that contain zeros.

// File: rtl/srpo_pkg.sv
`timescale 1ns/1ps
package srpo_pkg;
  localparam int unsigned SRPO_STAGES = 8;
endpackage

// File: rtl/srpo_shift_chain.sv
`timescale 1ns/1ps
module srpo_shift_chain #(
  parameter int unsigned STAGES = srpo_pkg::SRPO_STAGES
) (
  input  logic              sh_clk,
  input  logic              clr_n,
  input  logic              ser,
  output logic [STAGES-1:0] chain_q,
  output logic              casc
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], ser};
  end

  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign casc = chain_q[LAST];

  // Checker state: high once a shift edge has passed since the last clear
  logic armed_q;
  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always @(posedge sh_clk) begin
    if (!clr_n) begin
      p_chain_zero_r2: assert (chain_q == '0)
        else $error("shift chain not empty while clear held");
    end
  end

  p_first_stage_r1: assert property (@(posedge sh_clk) disable iff (!clr_n)
    armed_q |-> chain_q[0] == $past(ser));

  p_inner_stages_r1: assert property (@(posedge sh_clk) disable iff (!clr_n)
    armed_q |-> chain_q[LAST:1] == $past(chain_q[LAST-1:0]));

  p_cascade_r6: assert property (@(posedge sh_clk) disable iff (!clr_n)
    armed_q |-> casc == $past(chain_q[LAST-1]));
endmodule

// File: rtl/srpo_store_rank.sv
`timescale 1ns/1ps
module srpo_store_rank #(
  parameter int unsigned STAGES = srpo_pkg::SRPO_STAGES
) (
  input  logic              st_clk,
  input  logic              clr_n,
  input  logic [STAGES-1:0] chain_in,
  output logic [STAGES-1:0] store_q
);
  always_ff @(posedge st_clk) begin
    store_q <= chain_in;
  end

  p_capture_r4: assert property (@(posedge st_clk) disable iff (!clr_n)
    1'b1 |=> store_q == $past(chain_in));
endmodule

// File: rtl/srpo_tristate_drv.sv
`timescale 1ns/1ps
module srpo_tristate_drv #(
  parameter int unsigned STAGES = srpo_pkg::SRPO_STAGES
) (
  input  logic              oe_n,
  input  logic [STAGES-1:0] data,
  output logic [STAGES-1:0] pins
);
  assign pins = oe_n ? {STAGES{1'bz}} : data;
endmodule

// File: rtl/srpo_dual_rank.sv
`timescale 1ns/1ps
module srpo_dual_rank #(
  parameter int unsigned STAGES = srpo_pkg::SRPO_STAGES
) (
  input  logic              sh_clk_i,
  input  logic              st_clk_i,
  input  logic              clr_ni,
  input  logic              ser_i,
  input  logic              oe_ni,
  output logic [STAGES-1:0] par_o,
  output logic              casc_o
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] store;

  srpo_shift_chain #(.STAGES(STAGES)) u_chain (
    .sh_clk  (sh_clk_i),
    .clr_n   (clr_ni),
    .ser     (ser_i),
    .chain_q (chain),
    .casc    (casc_o)
  );

  srpo_store_rank #(.STAGES(STAGES)) u_store (
    .st_clk   (st_clk_i),
    .clr_n    (clr_ni),
    .chain_in (chain),
    .store_q  (store)
  );

  srpo_tristate_drv #(.STAGES(STAGES)) u_drv (
    .oe_n (oe_ni),
    .data (store),
    .pins (par_o)
  );
endmodule

// File: tb/srpo_dual_rank_test.sv
`timescale 1ns/1ps
module srpo_dual_rank_test;
  logic clk = 1'b0;
  logic sh_g = 1'b0, st_g = 1'b0;
  logic clr_n = 1'b0, ser = 1'b0, oe_n = 1'b1;
  wire  sh_clk = clk & sh_g;
  wire  st_clk = clk & st_g;
  wire [7:0] pa, pb;
  wire casc_a, casc_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model: m_chain[7:0] is the first device, m_chain[15:8] the second
  logic [15:0] m_chain = '0;
  logic [7:0]  m_st_a = '0, m_st_b = '0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pull
    pullup (pa[i]);
    pullup (pb[i]);
  end

  srpo_dual_rank uut (
    .sh_clk_i(sh_clk), .st_clk_i(st_clk), .clr_ni(clr_n), .ser_i(ser),
    .oe_ni(oe_n), .par_o(pa), .casc_o(casc_a));

  srpo_dual_rank uut_b (
    .sh_clk_i(sh_clk), .st_clk_i(st_clk), .clr_ni(clr_n), .ser_i(casc_a),
    .oe_ni(oe_n), .par_o(pb), .casc_o(casc_b));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock pulse on the selected clocks, then update the model
  task automatic pulse(input logic s, input logic do_sh, input logic do_st);
    @(negedge clk);
    ser = s; sh_g = do_sh; st_g = do_st;
    @(negedge clk);
    sh_g = 1'b0; st_g = 1'b0;
    if (do_st) begin m_st_a = m_chain[7:0]; m_st_b = m_chain[15:8]; end
    if (do_sh && clr_n) m_chain = {m_chain[14:0], s};
  endtask

  task automatic chk_pins(input string tag);
    chk({8'h0, pa}, {8'h0, oe_n ? 8'hFF : m_st_a}, tag);
    chk({8'h0, pb}, {8'h0, oe_n ? 8'hFF : m_st_b}, tag);
  endtask

  task automatic t_reset;
    #1;
    chk({15'h0, casc_a}, 16'h0, "R2 cascade after clear");
    chk({8'h0, pa}, 16'h00FF, "R5 pins float at start");
    @(negedge clk); clr_n = 1'b1;
    pulse(1'b0, 1'b0, 1'b1);
    @(negedge clk); oe_n = 1'b0; #1;
    chk_pins("R4 zero word loaded");
  endtask

  task automatic t_chain16;
    logic [15:0] pat = 16'hC3A5;
    for (int i = 15; i >= 0; i--) begin
      pulse(pat[i], 1'b1, 1'b0);
      chk({15'h0, casc_a}, {15'h0, m_chain[7]}, "R6 cascade follows stage 7");
      chk({15'h0, casc_b}, {15'h0, m_chain[15]}, "R1 second device last stage");
    end
    chk_pins("R4 shift edges leave pins unchanged");
    pulse(1'b0, 1'b0, 1'b1);
    chk({8'h0, pb}, 16'h00C3, "R9 first byte on second device");
    chk({8'h0, pa}, 16'h00A5, "R9 last byte on first device");
    pulse(1'b1, 1'b1, 1'b0);
    chk_pins("R1 stage shift hidden until storage edge");
    pulse(1'b0, 1'b0, 1'b1);
    chk({8'h0, pa}, 16'h004B, "R1 one more shift, bit 0 is stage 0");
  endtask

  task automatic t_enable;
    @(negedge clk); oe_n = 1'b1; #1;
    chk_pins("R5 pins float with enable high");
    chk({15'h0, casc_a}, {15'h0, m_chain[7]}, "R6 cascade drives with enable high");
    for (int i = 0; i < 8; i++) pulse(i[0], 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    chk_pins("R8 capture while floating");
    @(negedge clk); oe_n = 1'b0; #1;
    chk({8'h0, pa}, {8'h0, m_st_a}, "R8 captured word appears on enable");
    chk({8'h0, pa}, 16'h0055, "R8 captured value");
  endtask

  task automatic t_clear;
    logic [7:0] held = m_st_a;
    @(negedge clk); clr_n = 1'b0; m_chain = '0; #1;
    chk({15'h0, casc_a}, 16'h0, "R2 cascade zero without clock");
    pulse(1'b1, 1'b1, 1'b0);
    chk({15'h0, casc_a}, 16'h0, "R2 shift ignored during clear");
    chk({8'h0, pa}, {8'h0, held}, "R3 pins keep word through clear");
    @(negedge clk); clr_n = 1'b1;
    pulse(1'b0, 1'b0, 1'b1);
    chk({8'h0, pa}, 16'h0000, "R3 zeros after storage edge");
    chk({8'h0, pb}, 16'h0000, "R3 zeros on second device");
  endtask

  task automatic t_tied;
    logic [7:0] pat = 8'b1101_0110;
    for (int i = 7; i >= 0; i--) begin
      pulse(pat[i], 1'b1, 1'b1);
      chk_pins("R7 storage one edge behind");
    end
    chk({8'h0, pa}, 16'h006B, "R7 word lags by one bit");
  endtask

  initial begin
    t_reset;
    t_chain16;
    t_enable;
    t_clear;
    t_tied;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule